// File: doc/BRIEF.md
# Upscaler Tile Parameter Calculator

This block turns one axis of an upscaling request into the values a fixed-point resampler needs. Given an input line length and an output line length, it produces a phase step with 15 fractional bits, a starting offset that centres the output grid on the input grid, and the lengths each tile consumes and produces. In dual-tile mode the line is split into a left and a right tile that overlap by a few pixels. The right tile gets its own start phase, and its integer offset is forced even.

A request is presented with a one-cycle `start` pulse. The step needs a long division, done by a restoring divider at one quotient bit per clock. When every output is valid, `done` pulses for one cycle. Requests that cannot be served raise `err` together with `done`. While the unit is busy, further `start` pulses are ignored.

Top module: `rtz_tile_calc`

## Requirements
- R1: `step` equals the ceiling of 32768·(in−1)/(out−1), computed as (32768·(in−1) + out − 2) / (out − 1) in unsigned integer division.
- R2: An output length of 0 or 1 is an error: `err`=1 and every numeric output is 0.
- R3: If in ≠ out and in > `tile_limit`, the request is an error with all numeric outputs 0. If in = out, a length above the limit is accepted.
- R4: The centring value c = (step·(out−1) − 32768·(in−1))/2 (floor) sets the left offsets. If c = 0, `l_int`=0 and `l_sub`=0. Otherwise the left subpixel offset −c is wrapped into [0, 32768) by adding 32768 and decrementing the integer part, giving `l_int`=16'hFFFF and `l_sub`=32768−c.
- R5: In single mode (`dual`=0), `l_in`=in and `l_out`=out. All right-tile outputs are 0.
- R6: In dual mode, `l_in` = floor(in/2) + 4 and both `l_out` and `r_out` equal floor(out/2).
- R7: The right phase is p = (32768 − c) + floor(out/2)·step − (floor(in/2) − 4 − f + 1)·32768 + 32768, with f = 1 when c ≠ 0. Its integer part is p/32768 rounded toward zero, and its subpixel part is p minus 32768 times that integer part. Integer outputs keep the low 16 bits and subpixel outputs keep the low 21 bits.
- R8: `r_in` = floor(in/2) + 4 + f. If the right integer part is odd, both that part and `r_in` are incremented by one.
- R9: `done` is high for exactly one cycle per accepted request. `start` while `busy`=1 is ignored and produces no extra result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when not busy |
| in_len | input | 16 | Frame input length |
| out_len | input | 16 | Frame output length |
| dual | input | 1 | 1 = split into two overlapping tiles |
| tile_limit | input | 16 | Largest input length that may be scaled |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Request rejected (valid with done) |
| step | output | 32 | Phase step, 15 fractional bits |
| l_int | output | 16 | Left tile integer offset |
| l_sub | output | 21 | Left tile subpixel offset |
| l_in | output | 16 | Left tile input length |
| l_out | output | 16 | Left tile output length |
| r_int | output | 16 | Right tile integer offset |
| r_sub | output | 21 | Right tile subpixel offset |
| r_in | output | 16 | Right tile input length |
| r_out | output | 16 | Right tile output length |

## Verification
The assertions take the request fields captured at acceptance as the request that `done` answers. This holds only if the environment gives each request as a single-cycle `start` and does not expect a second request to be queued while `busy` is high. The stimulus follows this rule for every regular request. It breaks the rule once on purpose, with a second `start` during a division, and then confirms that only one result comes back. Lengths stay within 16 bits, so the numerator fits the 32-bit divider and the centring value stays below 32768, which the left-offset range property depends on.

// File: rtl/rtz_pkg.sv
package rtz_pkg;
  localparam int LEN_W_D  = 16;
  localparam int FRAC_W_D = 15;
  localparam int INT_W_D  = 16;
  localparam int SUB_W_D  = 21;
  localparam int OVL_D    = 4;

  typedef logic signed [63:0] wide_t;

  typedef struct {
    wide_t ip;
    wide_t fp;
  } split_t;

  // numerator of the rounding-up step division
  function automatic logic [63:0] step_numer(input logic [63:0] in_l,
                                             input logic [63:0] out_l,
                                             input int frac);
    return ((in_l - 64'd1) << frac) + out_l - 64'd2;
  endfunction

  // request legality: too short an output, or scaling beyond the limit
  function automatic logic req_bad(input logic [63:0] in_l,
                                   input logic [63:0] out_l,
                                   input logic [63:0] lim);
    return (out_l <= 64'd1) || ((in_l != out_l) && (in_l > lim));
  endfunction

  // bring a subpixel value into [0, unit) adjusting the integer part
  function automatic split_t wrap_phase(input wide_t sub, input wide_t unit);
    split_t r;
    r.ip = '0;
    r.fp = sub;
    if (r.fp < 0) begin
      r.ip = r.ip - 1;
      r.fp = r.fp + unit;
    end
    if (r.fp >= unit) begin
      r.ip = r.ip + 1;
      r.fp = r.fp - unit;
    end
    return r;
  endfunction

  // integer/fraction split with the integer part rounded toward zero
  function automatic split_t trunc_split(input wide_t ph, input int frac);
    split_t r;
    if (ph >= 0) r.ip = ph >>> frac;
    else         r.ip = -((-ph) >>> frac);
    r.fp = ph - (r.ip <<< frac);
    return r;
  endfunction
endpackage

// File: rtl/rtz_divider.sv
module rtz_divider #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic             fin,
  output logic [NUM_W-1:0] quot
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] acc_q;
  logic [DEN_W:0]   rem_q;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {rem_q[DEN_W-1:0], acc_q[NUM_W-1]};
  assign fits  = trial >= {1'b0, den_q};
  assign quot  = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      rem_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        acc_q <= numer;
        rem_q <= '0;
        den_q <= denom;
        cnt_q <= CNT_W'(NUM_W);
      end else if (cnt_q != '0) begin
        rem_q <= fits ? (trial - {1'b0, den_q}) : trial;
        acc_q <= {acc_q[NUM_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        fin   <= (cnt_q == CNT_W'(1));
      end
    end
  end
endmodule

// File: rtl/rtz_tile_math.sv
module rtz_tile_math
  import rtz_pkg::*;
#(
  parameter int LEN_W  = LEN_W_D,
  parameter int FRAC_W = FRAC_W_D,
  parameter int STEP_W = 32,
  parameter int INT_W  = INT_W_D,
  parameter int SUB_W  = SUB_W_D,
  parameter int OVL    = OVL_D
) (
  input  logic [LEN_W-1:0]  in_len,
  input  logic [LEN_W-1:0]  out_len,
  input  logic              dual,
  input  logic [STEP_W-1:0] step,
  output logic [INT_W-1:0]  l_int,
  output logic [SUB_W-1:0]  l_sub,
  output logic [LEN_W-1:0]  l_in,
  output logic [LEN_W-1:0]  l_out,
  output logic [INT_W-1:0]  r_int,
  output logic [SUB_W-1:0]  r_sub,
  output logic [LEN_W-1:0]  r_in,
  output logic [LEN_W-1:0]  r_out
);
  wide_t unit, s_w, in_w, out_w, cen, f_w, ph, hin, hout, odd_w, rlen;
  split_t lsp, rsp;

  always_comb begin
    unit  = wide_t'(64'd1 << FRAC_W);
    s_w   = wide_t'(64'(step));
    in_w  = wide_t'(64'(in_len));
    out_w = wide_t'(64'(out_len));
    hin   = in_w >>> 1;
    hout  = out_w >>> 1;
    cen   = (s_w * (out_w - 1) - ((in_w - 1) <<< FRAC_W)) >>> 1;
    f_w   = (cen != 0) ? 64'sd1 : 64'sd0;
    lsp   = wrap_phase(-cen, unit);
    ph    = (unit - cen) + hout * s_w - (hin - OVL - f_w + 1) * unit + unit;
    rsp   = trunc_split(ph, FRAC_W);
    odd_w = {63'd0, rsp.ip[0]};
    rlen  = hin + OVL + f_w + odd_w;
    l_int = lsp.ip[INT_W-1:0];
    l_sub = lsp.fp[SUB_W-1:0];
    if (dual) begin
      l_in  = LEN_W'(hin + OVL);
      l_out = LEN_W'(hout);
      r_int = INT_W'(rsp.ip + odd_w);
      r_sub = rsp.fp[SUB_W-1:0];
      r_in  = rlen[LEN_W-1:0];
      r_out = LEN_W'(hout);
    end else begin
      l_in  = in_len;
      l_out = out_len;
      r_int = '0;
      r_sub = '0;
      r_in  = '0;
      r_out = '0;
    end
  end
endmodule

// File: rtl/rtz_tile_calc.sv
module rtz_tile_calc
  import rtz_pkg::*;
#(
  parameter int LEN_W  = LEN_W_D,
  parameter int FRAC_W = FRAC_W_D,
  parameter int INT_W  = INT_W_D,
  parameter int SUB_W  = SUB_W_D,
  parameter int OVL    = OVL_D,
  localparam int STEP_W = LEN_W + FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [LEN_W-1:0]  out_len,
  input  logic              dual,
  input  logic [LEN_W-1:0]  tile_limit,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [STEP_W-1:0] step,
  output logic [INT_W-1:0]  l_int,
  output logic [SUB_W-1:0]  l_sub,
  output logic [LEN_W-1:0]  l_in,
  output logic [LEN_W-1:0]  l_out,
  output logic [INT_W-1:0]  r_int,
  output logic [SUB_W-1:0]  r_sub,
  output logic [LEN_W-1:0]  r_in,
  output logic [LEN_W-1:0]  r_out
);
  // named events for the checker
  logic              accept, bad, go, div_fin;
  logic [STEP_W-1:0] quot, numer;
  logic [LEN_W-1:0]  in_q, out_q;
  logic              dual_q;
  logic [INT_W-1:0]  m_l_int, m_r_int;
  logic [SUB_W-1:0]  m_l_sub, m_r_sub;
  logic [LEN_W-1:0]  m_l_in, m_l_out, m_r_in, m_r_out;
  logic [63:0]       numer_w;

  assign accept  = start && !busy;
  assign bad     = req_bad(64'(in_len), 64'(out_len), 64'(tile_limit));
  assign go      = accept && !bad;
  assign numer_w = step_numer(64'(in_len), 64'(out_len), FRAC_W);
  assign numer   = numer_w[STEP_W-1:0];

  rtz_divider #(.NUM_W(STEP_W), .DEN_W(LEN_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(go), .numer(numer),
    .denom(out_len - 1'b1), .fin(div_fin), .quot(quot)
  );

  rtz_tile_math #(.LEN_W(LEN_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W),
                  .INT_W(INT_W), .SUB_W(SUB_W), .OVL(OVL)) u_math (
    .in_len(in_q), .out_len(out_q), .dual(dual_q), .step(quot),
    .l_int(m_l_int), .l_sub(m_l_sub), .l_in(m_l_in), .l_out(m_l_out),
    .r_int(m_r_int), .r_sub(m_r_sub), .r_in(m_r_in), .r_out(m_r_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; err <= 1'b0;
      in_q <= '0; out_q <= '0; dual_q <= 1'b0;
      step <= '0; l_int <= '0; l_sub <= '0; l_in <= '0; l_out <= '0;
      r_int <= '0; r_sub <= '0; r_in <= '0; r_out <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        in_q   <= in_len;
        out_q  <= out_len;
        dual_q <= dual;
        err    <= bad;
        if (bad) begin
          done <= 1'b1;
          step <= '0; l_int <= '0; l_sub <= '0; l_in <= '0; l_out <= '0;
          r_int <= '0; r_sub <= '0; r_in <= '0; r_out <= '0;
        end else begin
          busy <= 1'b1;
        end
      end else if (busy && div_fin) begin
        busy  <= 1'b0;
        done  <= 1'b1;
        step  <= quot;
        l_int <= m_l_int; l_sub <= m_l_sub; l_in <= m_l_in; l_out <= m_l_out;
        r_int <= m_r_int; r_sub <= m_r_sub; r_in <= m_r_in; r_out <= m_r_out;
      end
    end
  end
endmodule

// File: rtl/rtz_tile_calc_chk.sv
module rtz_tile_calc_chk #(
  parameter int LEN_W  = 16,
  parameter int INT_W  = 16,
  parameter int SUB_W  = 21,
  parameter int STEP_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [LEN_W-1:0]  in_q,
  input logic [LEN_W-1:0]  out_q,
  input logic              dual_q,
  input logic [STEP_W-1:0] step,
  input logic [SUB_W-1:0]  l_sub,
  input logic [LEN_W-1:0]  l_in,
  input logic [LEN_W-1:0]  l_out,
  input logic [INT_W-1:0]  r_int,
  input logic [LEN_W-1:0]  r_in
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(in_q) && $stable(out_q) && $stable(dual_q)));

  p_short_out_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && out_q <= LEN_W'(1)) |-> err);

  p_err_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (step == '0 && l_in == '0 && r_in == '0));

  p_left_sub_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (l_sub <= SUB_W'(32768)));

  p_single_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && !dual_q) |-> (l_in == in_q && l_out == out_q && r_in == '0));

  p_right_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && dual_q) |-> !r_int[0]);
endmodule

bind rtz_tile_calc rtz_tile_calc_chk #(
  .LEN_W(LEN_W), .INT_W(INT_W), .SUB_W(SUB_W), .STEP_W(STEP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .in_q(in_q), .out_q(out_q), .dual_q(dual_q), .step(step),
  .l_sub(l_sub), .l_in(l_in), .l_out(l_out), .r_int(r_int), .r_in(r_in)
);

// File: tb/rtz_tile_calc_bench.sv
module rtz_tile_calc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] in_len = '0, out_len = '0, tile_limit = '0;
  logic        dual = 1'b0;
  logic        busy, done, err;
  logic [31:0] step;
  logic [15:0] l_int, l_in, l_out, r_int, r_in, r_out;
  logic [20:0] l_sub, r_sub;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  bit prev_done = 1'b0;

  typedef struct {
    string tag;
    logic  err;
    logic [31:0] step;
    logic [15:0] l_int, l_in, l_out, r_int, r_in, r_out;
    logic [20:0] l_sub, r_sub;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;

  rtz_tile_calc u_rtz_tile_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .in_len(in_len), .out_len(out_len),
    .dual(dual), .tile_limit(tile_limit), .busy(busy), .done(done), .err(err),
    .step(step), .l_int(l_int), .l_sub(l_sub), .l_in(l_in), .l_out(l_out),
    .r_int(r_int), .r_sub(r_sub), .r_in(r_in), .r_out(r_out)
  );

  task automatic chk(input string tag, input longint act, input longint expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // reference model written from the requirements
  function automatic exp_t model(input string tag, input longint i, input longint o,
                                 input bit d, input longint lim);
    exp_t e;
    longint s, c, f, p, ri, rl;
    e = '{tag: tag, err: 1'b0, step: '0, l_int: '0, l_in: '0, l_out: '0,
          r_int: '0, r_in: '0, r_out: '0, l_sub: '0, r_sub: '0};
    if (o < 2 || (i != o && i > lim)) begin
      e.err = 1'b1;          // R2 / R3
      return e;
    end
    s = (32768 * (i - 1) + o - 2) / (o - 1);   // R1
    e.step = 32'(s);
    c = (s * (o - 1) - 32768 * (i - 1)) / 2;   // R4
    f = (c != 0) ? 1 : 0;
    if (c != 0) begin
      e.l_int = 16'hFFFF;
      e.l_sub = 21'(32768 - c);
    end
    if (!d) begin                              // R5
      e.l_in = 16'(i);
      e.l_out = 16'(o);
      return e;
    end
    e.l_in  = 16'(i / 2 + 4);                  // R6
    e.l_out = 16'(o / 2);
    e.r_out = 16'(o / 2);
    p  = (32768 - c) + (o / 2) * s - (i / 2 - 4 - f + 1) * 32768 + 32768;  // R7
    ri = p / 32768;
    e.r_sub = 21'(p - 32768 * ri);
    rl = i / 2 + 4 + f;                        // R8
    if ((ri % 2) != 0) begin
      ri = ri + 1;
      rl = rl + 1;
    end
    e.r_int = 16'(ri);
    e.r_in  = 16'(rl);
    return e;
  endfunction

  task automatic request(input string tag, input int i, input int o,
                         input bit d, input int lim);
    sb.push_back(model(tag, i, o, d, lim));
    @(negedge clk);
    in_len = 16'(i); out_len = 16'(o); dual = d; tile_limit = 16'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops and compares each result
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) chk("R9 done width", 1, 0);
      if (done) begin
        if (sb.size() == 0) chk("R9 unexpected result", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk({e.tag, " err"},   err,   e.err);
          chk({e.tag, " step"},  step,  e.step);
          chk({e.tag, " l_int"}, l_int, e.l_int);
          chk({e.tag, " l_sub"}, l_sub, e.l_sub);
          chk({e.tag, " l_in"},  l_in,  e.l_in);
          chk({e.tag, " l_out"}, l_out, e.l_out);
          chk({e.tag, " r_int"}, r_int, e.r_int);
          chk({e.tag, " r_sub"}, r_sub, e.r_sub);
          chk({e.tag, " r_in"},  r_in,  e.r_in);
          chk({e.tag, " r_out"}, r_out, e.r_out);
        end
      end
      prev_done = done;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset busy", busy, 0);
    chk("reset done", done, 0);
    chk("reset step", step, 0);

    request("R1 R5 single 100->200", 100, 200, 1'b0, 1440);
    request("R1 R4 single equal",    100, 100, 1'b0, 1440);
    request("R4 R5 single 3->7",     3, 7, 1'b0, 1440);
    request("R6 R7 R8 dual 720->1080", 720, 1080, 1'b1, 1440);
    request("R6 R7 R8 dual 540->1080", 540, 1080, 1'b1, 1440);
    request("R7 R8 dual 101->303",   101, 303, 1'b1, 1440);
    request("R7 R8 dual small 3->7", 3, 7, 1'b1, 1440);
    request("R8 dual 1000->1999",    1000, 1999, 1'b1, 1440);
    request("R2 out one",            10, 1, 1'b0, 1440);
    request("R2 out zero",           10, 0, 1'b1, 1440);
    request("R3 over limit",         2000, 3000, 1'b0, 1440);
    request("R3 no scaling above limit", 2000, 2000, 1'b1, 1440);
    request("R3 at limit",           1440, 2000, 1'b0, 1440);

    // R9: a second start during the division must be ignored
    sb.push_back(model("R9 busy ignore", 300, 900, 1'b1, 1440));
    @(negedge clk);
    in_len = 16'd300; out_len = 16'd900; dual = 1'b1; tile_limit = 16'd1440;
    start = 1'b1;
    @(negedge clk);
    chk("R9 busy after accept", busy, 1);
    in_len = 16'd50; out_len = 16'd70; dual = 1'b0;
    @(negedge clk);
    start = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    chk("R9 idle after single result", busy, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule